// File: doc/BRIEF.md
# MDIO Management Master (Clause 22)

This block drives the two-wire station management bus used to configure an external Ethernet PHY. It derives the management clock from the system clock and sends complete 64-bit read or write frames, addressing one of 32 PHYs and one of 32 registers in each.

Software first loads a 16-bit data register and then writes a control register. That register holds the PHY address, the register address, the clock-range code, a write flag and a busy bit. Writing the control register with busy set starts a frame. Hardware clears busy when the frame ends, and software polls busy to learn that the frame is done. After a read, the data register holds the 16 bits returned by the PHY. The clock-range code and the address fields stay in the control register across every operation. Only the standard start and opcode patterns are produced.

Top module: `mdio_master`

## Requirements
- R1: After reset, the data register and the control register read zero, and `mdc` and `mdio_oe` are low.
- R2: A control write accepted while idle with bit 0 (busy) set starts a frame. Busy reads 1 until the frame completes and then reads 0. Busy falls on the same clock edge on which `mdc` falls after the last bit.
- R3: A write frame (bit 1 set) sends 64 bits, MSB first. The bits are 32 ones, start 01, opcode 01, the PHY address from bits 15:11, the register address from bits 10:6, turnaround 10, and then the data register.
- R4: A read frame (bit 1 clear) uses opcode 10 and drives the bus for the first 46 bits only. `mdio_oe` is low during the turnaround bits, during the 16 data bits and whenever the block is idle.
- R5: In a read, `mdio_i` is sampled at each of the 16 rising `mdc` edges of the data phase, MSB first. The data register is loaded with the result when the frame completes.
- R6: The clock-range code in control bits 4:2 sets the `mdc` period in system clocks. The codes 0 to 5 give 16, 26, 42, 62, 102 and 124 clocks, and codes 6 and 7 give 124 clocks. Between frames `mdc` is held low.
- R7: When hardware clears busy, the PHY address, the register address, the clock-range code and the write flag keep the values that were written. Bit 5 always reads 0.
- R8: Control writes made while busy is set are ignored. They do not change the register, and they do not start an extra frame.
- R9: `mdio_o` changes only on a clock edge where `mdc` falls or where a frame starts.
- R10: A control write with busy clear, made while idle, updates the fields without starting a frame.
- R11: A write frame leaves the data register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_we | input | 1 | Write strobe for the data register |
| data_wdata | input | 16 | Value for the data register |
| ctrl_we | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 16 | Value for the control register |
| data_q | output | 16 | Data register contents |
| ctrl_q | output | 16 | Control register contents (bit 0 = busy) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Output enable for the management data pin |
| mdio_i | input | 1 | Management data in |

## Verification
A bus-model monitor decodes every frame on the rising edges of `mdc` and compares each driven bit and each output-enable state against the transaction that the driver queued.

- **Read turnaround.** A design that got the turnaround wrong would drive the bus while the PHY answers. The monitor reports this as a set output enable in bits 46 to 63.
- **Capture edge.** A capture made on the wrong edge, or shifted by one bit, shows up as a wrong value in the data register. The PHY model changes its data only on falling edges, so sampling on anything other than a rising edge picks up the wrong bits.
- **Clock range.** Each range code is checked by timing the first `mdc` period. A clear of busy that wiped the other fields appears in the control register read-back.
- **Write while busy.** A control write made mid-frame must neither alter the fields nor queue a second frame. The monitor flags any frame that it has no transaction for.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 5;
  localparam int PRE_BITS  = 32;
  localparam int FRAME_W   = PRE_BITS + 4 + 2 * ADDR_W + 2 + DATA_W;
  localparam int TA_START  = FRAME_W - DATA_W - 2;
  localparam int DATA_START = FRAME_W - DATA_W;
  localparam int IDX_W     = $clog2(FRAME_W) + 1;
  localparam int CNT_W     = 6;
  localparam int RANGE_W   = 3;

  typedef struct packed {
    logic [ADDR_W-1:0]  phy;
    logic [ADDR_W-1:0]  regad;
    logic               rsv;
    logic [RANGE_W-1:0] range;
    logic               wr;
    logic               busy;
  } ctrl_t;

  function automatic logic [CNT_W-1:0] half_cycles(input logic [RANGE_W-1:0] code);
    case (code)
      3'd0:    half_cycles = CNT_W'(8);
      3'd1:    half_cycles = CNT_W'(13);
      3'd2:    half_cycles = CNT_W'(21);
      3'd3:    half_cycles = CNT_W'(31);
      3'd4:    half_cycles = CNT_W'(51);
      default: half_cycles = CNT_W'(62);
    endcase
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] half,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mdc_d;
  logic             at_end;

  always_comb begin
    at_end = run && (cnt_q == half - CNT_W'(1));
    rise   = at_end && !mdc;
    fall   = at_end && mdc;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (at_end) begin
      cnt_d = '0;
      mdc_d = !mdc;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
      mdc_d = mdc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc   <= mdc_d;
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_wr,
  input  logic [ADDR_W-1:0] phy,
  input  logic [ADDR_W-1:0] regad,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise,
  input  logic              fall,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_W - 1);

  logic               act_q, act_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic               mo_d, oe_d;
  logic               wr_q, wr_d;
  logic [DATA_W-1:0]  cap_q, cap_d;
  logic [FRAME_W-1:0] frame;
  logic [IDX_W-1:0]   idx_inc;

  always_comb begin
    frame = {{PRE_BITS{1'b1}}, 2'b01, (is_wr ? 2'b01 : 2'b10), phy, regad,
             (is_wr ? 2'b10 : 2'b11), (is_wr ? wdata : {DATA_W{1'b1}})};
    idx_inc = idx_q + IDX_W'(1);
    done  = act_q && fall && (idx_q == LAST);
    act_d = act_q;
    idx_d = idx_q;
    sh_d  = sh_q;
    mo_d  = mdio_o;
    oe_d  = mdio_oe;
    wr_d  = wr_q;
    cap_d = cap_q;
    if (start) begin
      act_d = 1'b1;
      idx_d = '0;
      sh_d  = frame;
      mo_d  = frame[FRAME_W-1];
      oe_d  = 1'b1;
      wr_d  = is_wr;
      cap_d = '0;
    end else if (act_q) begin
      if (rise && !wr_q && (idx_q >= IDX_W'(DATA_START)))
        cap_d = {cap_q[DATA_W-2:0], mdio_i};
      if (fall) begin
        if (idx_q == LAST) begin
          act_d = 1'b0;
          oe_d  = 1'b0;
        end else begin
          idx_d = idx_inc;
          sh_d  = sh_q << 1;
          mo_d  = sh_q[FRAME_W-2];
          oe_d  = wr_q || (idx_inc < IDX_W'(TA_START));
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      idx_q   <= '0;
      sh_q    <= '0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
      wr_q    <= 1'b0;
      cap_q   <= '0;
    end else begin
      act_q   <= act_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      mdio_o  <= mo_d;
      mdio_oe <= oe_d;
      wr_q    <= wr_d;
      cap_q   <= cap_d;
    end
  end

  assign rdata = cap_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_we,
  input  logic [DATA_W-1:0] data_wdata,
  input  logic              ctrl_we,
  input  logic [15:0]       ctrl_wdata,
  output logic [DATA_W-1:0] data_q,
  output logic [15:0]       ctrl_q,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  ctrl_t             ctrl_r, ctrl_d, ctrl_w;
  logic [DATA_W-1:0] data_d;
  logic              start, done, rise, fall;
  logic [DATA_W-1:0] rdata;

  always_comb begin
    ctrl_w = ctrl_t'(ctrl_wdata);
    start  = ctrl_we && !ctrl_r.busy && ctrl_w.busy;
    ctrl_d = ctrl_r;
    if (done) begin
      ctrl_d.busy = 1'b0;
    end else if (ctrl_we && !ctrl_r.busy) begin
      ctrl_d     = ctrl_w;
      ctrl_d.rsv = 1'b0;
    end
    data_d = data_q;
    if (done && !ctrl_r.wr)
      data_d = rdata;
    else if (data_we)
      data_d = data_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_r <= '0;
      data_q <= '0;
    end else begin
      ctrl_r <= ctrl_d;
      data_q <= data_d;
    end
  end

  assign ctrl_q = ctrl_r;

  mdio_clkgen clk_i (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (ctrl_r.busy),
    .half (half_cycles(ctrl_r.range)),
    .mdc  (mdc),
    .rise (rise),
    .fall (fall)
  );

  mdio_frame_seq seq_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .is_wr  (ctrl_w.wr),
    .phy    (ctrl_w.phy),
    .regad  (ctrl_w.regad),
    .wdata  (data_q),
    .rise   (rise),
    .fall   (fall),
    .mdio_i (mdio_i),
    .mdio_o (mdio_o),
    .mdio_oe(mdio_oe),
    .done   (done),
    .rdata  (rdata)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] ctrl_q,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  logic busy;
  assign busy = ctrl_q[0];

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdio_oe && !mdc));

  assert_done_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $fell(mdc));

  assert_fields_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (ctrl_q[15:1] == $past(ctrl_q[15:1])));

  assert_locked_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ctrl_q[15:1]));

  assert_out_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_o != $past(mdio_o)) |-> ($fell(mdc) || $rose(busy)));

  assert_rsv_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[5]);
endmodule

bind mdio_master mdio_master_chk chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .ctrl_q (ctrl_q),
  .mdc    (mdc),
  .mdio_o (mdio_o),
  .mdio_oe(mdio_oe)
);

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        data_we = 1'b0;
  logic [15:0] data_wdata = '0;
  logic        ctrl_we = 1'b0;
  logic [15:0] ctrl_wdata = '0;
  logic [15:0] data_q;
  logic [15:0] ctrl_q;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  typedef struct {
    bit          wr;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] wd;
    logic [15:0] rd;
    int          ratio;
  } item_t;

  item_t exp_q[$];

  always #2 clk = ~clk;

  mdio_master dut_i (
    .clk(clk), .rst_n(rst_n), .data_we(data_we), .data_wdata(data_wdata),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .data_q(data_q), .ctrl_q(ctrl_q),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int ratio_of(input logic [2:0] code);
    case (code)
      3'd0: return 16;
      3'd1: return 26;
      3'd2: return 42;
      3'd3: return 62;
      3'd4: return 102;
      default: return 124;
    endcase
  endfunction

  function automatic logic [15:0] ctrl_word(input logic [4:0] phy, input logic [4:0] ra,
                                            input logic [2:0] code, input bit wr, input bit busy);
    return {phy, ra, 1'b0, code, wr, busy};
  endfunction

  task automatic wr_data(input logic [15:0] v);
    @(negedge clk); data_we = 1'b1; data_wdata = v;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic wr_ctrl(input logic [15:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (ctrl_q[0]);
  endtask

  // Driver: queue the expected frame, start it, and check the registers afterwards.
  task automatic run_op(input bit wr, input logic [4:0] phy, input logic [4:0] ra,
                        input logic [2:0] code, input logic [15:0] wd, input logic [15:0] rd,
                        input bit poke_busy);
    item_t it;
    logic [15:0] data_before;
    it.wr = wr; it.phy = phy; it.regad = ra; it.wd = wd; it.rd = rd; it.ratio = ratio_of(code);
    exp_q.push_back(it);
    wr_data(wd);
    data_before = data_q;
    wr_ctrl(ctrl_word(phy, ra, code, wr, 1'b1));
    @(negedge clk);
    check(ctrl_q[0] == 1'b1, "R2 busy set after start", ctrl_q, 1);
    if (poke_busy) begin
      repeat (300) @(negedge clk);
      wr_ctrl(ctrl_word(~phy, ~ra, ~code, ~wr, 1'b1));
      check(ctrl_q == ctrl_word(phy, ra, code, wr, 1'b1), "R8 write while busy ignored",
            ctrl_q, ctrl_word(phy, ra, code, wr, 1'b1));
    end
    wait_idle();
    check(ctrl_q == ctrl_word(phy, ra, code, wr, 1'b0), "R7 fields kept on completion",
          ctrl_q, ctrl_word(phy, ra, code, wr, 1'b0));
    check(!mdc && !mdio_oe, "R4 idle bus released", {mdc, mdio_oe}, 0);
    if (wr) check(data_q == data_before, "R11 data kept after write", data_q, data_before);
    else    check(data_q == rd, "R5 read data loaded", data_q, rd);
    repeat (50) @(negedge clk);
  endtask

  // Monitor: a PHY model that decodes each frame and compares it with the queue.
  initial begin : monitor
    item_t it;
    logic [63:0] ef;
    bit bad_bit, bad_oe;
    realtime t0;
    forever begin
      @(posedge mdc);
      t0 = $realtime;
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected frame", 1, 0);
        it.wr = 1; it.phy = 0; it.regad = 0; it.wd = 0; it.rd = 0; it.ratio = 0;
      end else begin
        it = exp_q.pop_front();
      end
      ef = {32'hFFFF_FFFF, 2'b01, (it.wr ? 2'b01 : 2'b10), it.phy, it.regad, 2'b10, it.wd};
      bad_bit = 0; bad_oe = 0;
      for (int i = 0; i < 64; i++) begin
        if (i > 0) @(posedge mdc);
        if (i == 1)
          check($realtime - t0 == 4.0 * it.ratio, "R6 mdc period", int'(($realtime - t0) / 4.0), it.ratio);
        #1;
        if (it.wr || i < 46) begin
          if (!mdio_oe) bad_oe = 1;
          if (mdio_o !== ef[63-i]) bad_bit = 1;
        end else if (mdio_oe) begin
          bad_oe = 1;
        end
        if (!it.wr && i >= 47 && i < 63) begin
          @(negedge mdc);
          mdio_i = it.rd[15-(i-47)];
        end
      end
      @(negedge mdc);
      mdio_i = 1'b1;
      check(!bad_bit, it.wr ? "R3 write frame bits" : "R4 read frame header bits", bad_bit, 0);
      check(!bad_oe, it.wr ? "R3 write frame drive" : "R4 read turnaround release", bad_oe, 0);
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    check(data_q == 0 && ctrl_q == 0 && !mdc && !mdio_oe, "R1 reset state",
          {data_q, ctrl_q, mdc, mdio_oe}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(data_q == 0 && ctrl_q == 0 && !mdc && !mdio_oe, "R1 state after release",
          {data_q, ctrl_q, mdc, mdio_oe}, 0);

    run_op(1'b1, 5'h01, 5'h00, 3'd3, 16'hA5C3, 16'h0000, 1'b0);
    run_op(1'b0, 5'h1F, 5'h02, 3'd3, 16'h0000, 16'h1234, 1'b0);
    run_op(1'b0, 5'h0A, 5'h1F, 3'd0, 16'h0000, 16'h8001, 1'b0);
    run_op(1'b1, 5'h15, 5'h0A, 3'd1, 16'h0000, 16'h0000, 1'b0);
    run_op(1'b0, 5'h03, 5'h11, 3'd2, 16'hFFFF, 16'h6DB6, 1'b1);
    run_op(1'b1, 5'h10, 5'h05, 3'd7, 16'hFFFF, 16'h0000, 1'b0);

    // R10: fields update without busy, no frame follows
    wr_ctrl(ctrl_word(5'h07, 5'h09, 3'd4, 1'b1, 1'b0) | 16'h0020);
    check(ctrl_q == ctrl_word(5'h07, 5'h09, 3'd4, 1'b1, 1'b0), "R10 fields set without start",
          ctrl_q, ctrl_word(5'h07, 5'h09, 3'd4, 1'b1, 1'b0));
    repeat (300) begin
      @(negedge clk);
      if (mdc || ctrl_q[0]) break;
    end
    check(!mdc && !ctrl_q[0], "R10 no frame started", {mdc, ctrl_q[0]}, 0);
    run_op(1'b1, 5'h07, 5'h09, 3'd4, 16'h5A5A, 16'h0000, 1'b0);

    check(exp_q.size() == 0, "R2 every queued frame seen", exp_q.size(), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule